// File: doc/BRIEF.md
# TDC Hit Timestamp Extender

This block serves one detector channel. It receives a single stream of TDC words in which coarse timestamp words are mixed with hit words. A hit word carries only a 22-bit fine time. The block keeps the coarse time from the most recent timestamp word. For every accepted hit it joins that coarse time with the hit's fine field to form a 40-bit absolute hit time, and it writes the result into a first-in-first-out queue.

A small output state machine pops the queue when the downstream side enables it. It places the word on the output bus and raises a ready strobe for one cycle. The queue's empty status is visible at the ports at all times.

The block comes in two variants selected by a parameter: a high-threshold channel with an 8-entry queue and a low-threshold channel with a 16-entry queue. The width of the overlap between the coarse and fine fields is a parameter.

Top module: `hit_time_extender`

## Requirements
- R1: A word with `in_valid`=1 and `in_is_ts`=1 is a timestamp word. It replaces the stored coarse time with word bits [CO_W-1:0], where CO_W = 40-22+OVERLAP_W (20 with the default OVERLAP_W=2). Word bits above CO_W-1 are ignored.
- R2: A word with `in_valid`=1 and `in_is_ts`=0 is a hit word. Its queued time has bits [21:0] equal to word bits [21:0], and bits [39:22] equal to stored coarse bits [CO_W-1:OVERLAP_W]. The low OVERLAP_W coarse bits are overridden by the fine field.
- R3: A hit word that arrives after reset but before any timestamp word is dropped. A word presented with `in_valid`=0 has no effect on the stored coarse time or on the queue.
- R4: Words leave in arrival order. The queue holds 8 entries when HIGH_THR=1 and 16 entries when HIGH_THR=0.
- R5: A hit that arrives while the queue is full is discarded and sets `overflow`. `overflow` stays set until reset.
- R6: `out_ready` is high for exactly one cycle per output word, and `out_data` holds that word and keeps it afterwards. The queue is popped only while `out_enable`=1, at most once every two cycles. With an empty queue and `out_enable`=1, a hit sampled at clock edge k gives `out_ready`=1 after edge k+1.
- R7: `out_empty` is 1 exactly when the queue holds no entry. After reset `out_empty`=1, `out_ready`=0, `overflow`=0 and `out_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word strobe |
| in_is_ts | input | 1 | 1: timestamp word, 0: hit word |
| in_word | input | 22 | Input word payload |
| out_enable | input | 1 | Downstream allows a pop |
| out_ready | output | 1 | One-cycle strobe marking a new output word |
| out_data | output | 40 | Reconstructed hit time |
| out_empty | output | 1 | Queue is empty |
| overflow | output | 1 | Sticky flag: a hit was lost to a full queue |

## Verification
A hit is written into the queue at the edge that samples it, so `out_empty` falls one edge after the stimulus. With the output enabled and idle, the pop happens on the following edge, so `out_ready` and `out_data` are due two edges after the stimulus. `overflow` is due one edge after the rejected hit. All inputs change on the falling clock edge and all outputs are read on falling edges, counted from the edge that sampled the stimulus. Readout checks wait for the ready strobe within a bounded window, and then confirm that the strobe is low on the next falling edge.

// File: rtl/hte_pkg.sv
package hte_pkg;
  localparam int FINE_W = 22;
  localparam int TIME_W = 40;
  localparam int HI_W   = TIME_W - FINE_W;

  // Upper time bits come from the coarse register, the lower from the fine field.
  function automatic logic [TIME_W-1:0] join_time(input logic [HI_W-1:0] coarse_hi,
                                                  input logic [FINE_W-1:0] fine);
    return {coarse_hi, fine};
  endfunction
endpackage

// File: rtl/hte_ts_tracker.sv
module hte_ts_tracker
  import hte_pkg::*;
#(
  parameter int OVERLAP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_is_ts,
  input  logic [FINE_W-1:0] in_word,
  output logic              hit_evt,
  output logic              ts_seen,
  output logic [TIME_W-1:0] hit_time
);
  localparam int CO_W = HI_W + OVERLAP_W;

  logic [HI_W-1:0] coarse_hi;
  logic            ts_evt;

  assign ts_evt   = in_valid && in_is_ts;
  assign hit_evt  = in_valid && !in_is_ts && ts_seen;
  assign hit_time = join_time(coarse_hi, in_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_hi <= '0;
      ts_seen   <= 1'b0;
    end else if (ts_evt) begin
      coarse_hi <= in_word[CO_W-1:OVERLAP_W];
      ts_seen   <= 1'b1;
    end
  end

  AST_TS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_is_ts) |=> $stable(coarse_hi)); // R3
endmodule

// File: rtl/hte_fifo.sv
module hte_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  assign empty   = (count == 0);
  assign full    = (count == DEPTH[AW:0]);
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + (AW+1)'(wr_en) - (AW+1)'(rd_en);
    end
  end

  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (rst) !(wr_en && full)); // R5
  AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty); // R4
endmodule

// File: rtl/hte_out_fsm.sv
module hte_out_fsm
  import hte_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              out_enable,
  input  logic              q_empty,
  input  logic [TIME_W-1:0] q_data,
  output logic              pop,
  output logic              out_ready,
  output logic [TIME_W-1:0] out_data
);
  typedef enum logic {S_IDLE, S_SHOW} state_t;
  state_t state;

  assign pop       = (state == S_IDLE) && !q_empty && out_enable;
  assign out_ready = (state == S_SHOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      out_data <= '0;
    end else if (pop) begin
      state    <= S_SHOW;
      out_data <= q_data;
    end else begin
      state    <= S_IDLE;
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst) out_ready |=> !out_ready); // R6
  AST_DATA_HELD:   assert property (@(posedge clk) disable iff (rst) !pop |=> $stable(out_data)); // R6
endmodule

// File: rtl/hit_time_extender.sv
module hit_time_extender
  import hte_pkg::*;
#(
  parameter bit HIGH_THR  = 1'b0,
  parameter int OVERLAP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_is_ts,
  input  logic [FINE_W-1:0] in_word,
  input  logic              out_enable,
  output logic              out_ready,
  output logic [TIME_W-1:0] out_data,
  output logic              out_empty,
  output logic              overflow
);
  localparam int DEPTH = HIGH_THR ? 8 : 16;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic              hit_evt, ts_seen, q_full, q_empty, pop, push, drop;
  logic [TIME_W-1:0] hit_time, q_data;
  logic [CW-1:0]     q_count;

  hte_ts_tracker #(.OVERLAP_W(OVERLAP_W)) u_trk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_ts(in_is_ts),
    .in_word(in_word), .hit_evt(hit_evt), .ts_seen(ts_seen), .hit_time(hit_time));

  assign push = hit_evt && !q_full;
  assign drop = hit_evt && q_full;

  hte_fifo #(.W(TIME_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data(hit_time), .rd_en(pop),
    .rd_data(q_data), .empty(q_empty), .full(q_full), .count(q_count));

  hte_out_fsm u_out (
    .clk(clk), .rst(rst), .out_enable(out_enable), .q_empty(q_empty),
    .q_data(q_data), .pop(pop), .out_ready(out_ready), .out_data(out_data));

  always_ff @(posedge clk) begin
    if (rst)       overflow <= 1'b0;
    else if (drop) overflow <= 1'b1;
  end

  assign out_empty = q_empty;

  AST_OVF_STICKY:   assert property (@(posedge clk) disable iff (rst) overflow |=> overflow); // R5
  AST_NO_EARLY_HIT: assert property (@(posedge clk) disable iff (rst)
    (q_count > $past(q_count)) |-> $past(ts_seen)); // R3
endmodule

// File: tb/tb_hit_time_extender.sv
module tb_hit_time_extender;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_is_ts = 1'b0, out_enable = 1'b0;
  logic [21:0] in_word = '0;
  logic        out_ready, out_empty, overflow;
  logic [39:0] out_data;
  logic        hi_ready, hi_empty, hi_ovf;
  logic [39:0] hi_data;

  int checks = 0, fails = 0;
  logic [39:0] expq [64];
  int exp_n = 0;
  logic [19:0] m_coarse = '0;
  logic        m_seen = 1'b0;

  always #2.5 clk = ~clk;

  hit_time_extender #(.HIGH_THR(1'b0)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_ts(in_is_ts), .in_word(in_word),
    .out_enable(out_enable), .out_ready(out_ready), .out_data(out_data),
    .out_empty(out_empty), .overflow(overflow));

  hit_time_extender #(.HIGH_THR(1'b1)) dut_hi (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_ts(in_is_ts), .in_word(in_word),
    .out_enable(out_enable), .out_ready(hi_ready), .out_data(hi_data),
    .out_empty(hi_empty), .overflow(hi_ovf));

  // bit 22 = timestamp flag, bits 21:0 = word
  localparam logic [22:0] VEC [10] = '{
    {1'b1, 22'h0ABCDE}, {1'b0, 22'h123456}, {1'b0, 22'h3FFFFF}, {1'b1, 22'h0FFFFF},
    {1'b0, 22'h000000}, {1'b0, 22'h000001}, {1'b1, 22'h300003}, {1'b0, 22'h200000},
    {1'b0, 22'h000155}, {1'b1, 22'h000004}};

  function automatic logic [39:0] model_time(input logic [19:0] c, input logic [21:0] f);
    logic [39:0] t;
    t = 40'(c) >> 2;
    return (t << 22) | 40'(f);
  endfunction

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic ts, input logic [21:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_is_ts = ts; in_word = w;
    if (ts) begin m_coarse = w[19:0]; m_seen = 1'b1; end
    else if (m_seen && exp_n < 64) begin expq[exp_n] = model_time(m_coarse, w); exp_n++; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; out_enable = 1'b0; in_valid = 1'b0;
    m_seen = 1'b0; m_coarse = '0; exp_n = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drain(input int n, input string req);
    int got = 0;
    out_enable = 1'b1;
    for (int t = 0; t < 200 && got < n; t++) begin
      @(negedge clk);
      if (out_ready) begin
        check(req, out_data, expq[got]);
        got++;
        @(negedge clk);
        check({req, " R6 pulse"}, 40'(out_ready), 40'd0);
      end
    end
    check({req, " count"}, 40'(got), 40'(n));
    out_enable = 1'b0;
    exp_n = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R7 reset state
    check("R7 empty", 40'(out_empty), 40'd1);
    check("R7 ready", 40'(out_ready), 40'd0);
    check("R7 ovf", 40'(overflow), 40'd0);
    check("R7 data", out_data, 40'd0);

    // R3: hit before any timestamp is dropped
    send(1'b0, 22'h00AAAA);
    check("R3 early hit", 40'(out_empty), 40'd1);

    // R1/R2/R4: table walk
    for (int i = 0; i < 10; i++) send(VEC[i][22], VEC[i][21:0]);
    check("R7 not empty", 40'(out_empty), 40'd0);
    drain(exp_n, "R2 R4 table");
    check("R7 empty after drain", 40'(out_empty), 40'd1);

    // R3: invalid timestamp word ignored (coarse stays 0x00004)
    @(negedge clk);
    in_valid = 1'b0; in_is_ts = 1'b1; in_word = 22'h0FFFFF;
    @(negedge clk);
    in_valid = 1'b0; in_is_ts = 1'b0; in_word = 22'h000007;
    @(negedge clk);
    check("R3 invalid hit", 40'(out_empty), 40'd1);
    send(1'b0, 22'h000009);
    drain(1, "R3 R1 coarse kept");

    // R6 latency: enable on, queue empty, hit sampled at edge k
    out_enable = 1'b1;
    send(1'b1, 22'h012345);
    @(negedge clk);
    in_valid = 1'b1; in_is_ts = 1'b0; in_word = 22'h054321;
    @(negedge clk);               // edge k passed
    in_valid = 1'b0;
    check("R6 not yet", 40'(out_ready), 40'd0);
    @(negedge clk);               // edge k+1 passed
    check("R6 ready due", 40'(out_ready), 40'd1);
    check("R6 data", out_data, model_time(20'h12345, 22'h054321));
    @(negedge clk);
    check("R6 single cycle", 40'(out_ready), 40'd0);
    check("R6 data held", out_data, model_time(20'h12345, 22'h054321));
    out_enable = 1'b0;

    // R4/R5: depths and overflow
    do_reset();
    send(1'b1, 22'h000100);
    for (int i = 1; i <= 8; i++) send(1'b0, 22'(i));
    check("R4 hi depth no ovf", 40'(hi_ovf), 40'd0);
    send(1'b0, 22'd9);
    check("R5 hi ovf", 40'(hi_ovf), 40'd1);
    check("R4 lo no ovf", 40'(overflow), 40'd0);
    for (int i = 10; i <= 16; i++) send(1'b0, 22'(i));
    check("R4 lo depth no ovf", 40'(overflow), 40'd0);
    send(1'b0, 22'd17);
    check("R5 lo ovf", 40'(overflow), 40'd1);
    exp_n = 16;
    drain(16, "R5 R4 order");
    check("R5 extra dropped", 40'(out_empty), 40'd1);
    check("R5 sticky", 40'(overflow), 40'd1);
    check("R5 hi sticky", 40'(hi_ovf), 40'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule